// File: doc/BRIEF.md
# Peak Bandwidth Monitor Counter

This block watches the traffic of several memory-bus masters and reports, for each master and for all masters together, the largest amount of data moved in any one measurement window. A prescaler divides the bus clock into base ticks, and a window is a programmed number of ticks long. Each lane adds up the bytes of its master's valid transfer strobes during a window. When the window closes, the lane scales the sum to bytes, KiB or MiB and keeps it if it is larger than the peak already held.

Software programs the prescaler and the window through a small register port and turns counting on. Some time later it reads the peak registers and compares them with the nominal bandwidth of the bus to judge how heavily the memory is loaded. Each time the enable bit goes from 0 to 1, every lane is cleared and a new measurement starts.

Top module: `peak_bw_monitor`

## Requirements
- R1: After reset, the timer register, the configuration register and every peak register read 0.
- R2: The timer register (offset 0x00) holds the prescale value in bits [PRE_W-1:0]. The configuration register (offset 0x04) holds the window length minus one in bits [31:16], the unit in bits [2:1] and the enable in bit 0. Both read back what was written, and an unmapped offset reads 0.
- R3: With timer value T and window value W, a window spans exactly (T+1)*(W+1) enabled bus cycles, counted from the first cycle after the enabling write. A window's sum becomes readable only after its last cycle has been registered.
- R4: At each window end the stored peak is replaced only when the new window sum is larger, so a lighter window never lowers it.
- R5: The peak of master i is read at offset 0xA0 + 4*i, and lanes do not affect each other. The combined lane at index NUM_MASTERS (offset 0xB4 with five masters) sums the bytes of all masters in the same window.
- R6: A byte count presented while its valid bit is low adds nothing.
- R7: Unit field 0 reports bytes, 1 reports KiB (sum shifted right by 10, rounding down), and 2 or 3 report MiB (sum shifted right by 20).
- R8: A configuration write that moves the enable bit from 0 to 1 clears every accumulator and peak and restarts the window timing.
- R9: While the enable bit is 0, transfers are not counted and the peaks keep their values.
- R10: A window accumulator that would exceed 2^CNT_W-1 stops at all-ones and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| xfer_vld | input | NUM_MASTERS | Per-master transfer valid |
| xfer_bytes | input | NUM_MASTERS*BYTE_W | Per-master byte count, master i in slice i |

## Verification
A register write takes effect at the clock edge that samples it. Read data follows reg_addr in the same cycle, so every check is made at the falling edge after the relevant rising edge. After an enabling write, the first counted cycle is the next edge, and a window of N cycles updates its peak at the N-th counted edge. The bench drives stimulus at falling edges for an exact number of cycles and reads one cycle before and at the edge of the window end, so an off-by-one in window length or alignment shows up as a wrong value. Saturation and unit shifts are checked with windows long enough to cross 2^20 and 2^24 bytes.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    typedef enum logic [1:0] {
        UNIT_BYTE    = 2'd0,
        UNIT_KIB     = 2'd1,
        UNIT_MIB     = 2'd2,
        UNIT_MIB_ALT = 2'd3
    } unit_e;

    localparam logic [7:0] ADDR_TIMER     = 8'h00;
    localparam logic [7:0] ADDR_CFG       = 8'h04;
    localparam logic [7:0] ADDR_PEAK_BASE = 8'hA0;

    function automatic int unsigned unit_shift(input unit_e u);
        case (u)
            UNIT_BYTE: return 0;
            UNIT_KIB:  return 10;
            default:   return 20;
        endcase
    endfunction

endpackage

// File: rtl/bwm_timebase.sv
module bwm_timebase #(
    parameter int PRE_W = 16,
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] presc,
    input  logic [WIN_W-1:0] win_len,
    output logic             tick,
    output logic             win_end
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [WIN_W-1:0] win;
    } tb_t;

    tb_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        tick    = run && (s_q.pre >= presc);
        win_end = tick && (s_q.win >= win_len);
        if (!run) begin
            s_d = '0;
        end else if (tick) begin
            s_d.pre = '0;
            s_d.win = win_end ? '0 : s_q.win + 1'b1;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/bwm_lane.sv
module bwm_lane
    import bwm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int IN_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             win_end,
    input  unit_e            unit,
    input  logic [IN_W-1:0]  add_val,
    output logic [CNT_W-1:0] peak,
    output logic [CNT_W-1:0] acc
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] peak;
    } lane_t;

    lane_t s_d, s_q;
    logic [CNT_W:0]   wide_sum;
    logic [CNT_W-1:0] sat_sum;
    logic [CNT_W-1:0] scaled;

    always_comb begin
        wide_sum = {1'b0, s_q.acc} + (CNT_W+1)'(add_val);
        sat_sum  = wide_sum[CNT_W] ? ALL_ONES : wide_sum[CNT_W-1:0];
        scaled   = sat_sum >> unit_shift(unit);
        s_d      = s_q;
        if (clr) begin
            s_d = '0;
        end else if (run) begin
            if (win_end) begin
                s_d.acc = '0;
                if (scaled > s_q.peak) s_d.peak = scaled;
            end else begin
                s_d.acc = sat_sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign peak = s_q.peak;
    assign acc  = s_q.acc;

endmodule

// File: rtl/peak_bw_monitor.sv
module peak_bw_monitor
    import bwm_pkg::*;
#(
    parameter int NUM_MASTERS = 5,
    parameter int BYTE_W      = 8,
    parameter int CNT_W       = 32,
    parameter int PRE_W       = 16,
    parameter int ADDR_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [NUM_MASTERS-1:0]        xfer_vld,
    input  logic [NUM_MASTERS*BYTE_W-1:0] xfer_bytes
);

    localparam int NUM_LANES = NUM_MASTERS + 1;
    localparam int SUM_W     = BYTE_W + $clog2(NUM_LANES);
    localparam int WIN_W     = 16;
    localparam int DATA_W    = 32;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic [WIN_W-1:0] win_len;
        unit_e            unit;
        logic             en;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  clr_now;
    logic  tick;
    logic  win_end;
    logic  unused_wdata;

    logic [SUM_W-1:0] lane_add  [NUM_LANES];
    logic [CNT_W-1:0] lane_peak [NUM_LANES];
    logic [CNT_W-1:0] lane_acc  [NUM_LANES];

    assign unused_wdata = ^reg_wdata;

    // register writes and enable edge
    always_comb begin
        rg_d    = rg_q;
        clr_now = 1'b0;
        if (reg_wr && reg_addr == ADDR_W'(ADDR_TIMER)) begin
            rg_d.presc = reg_wdata[PRE_W-1:0];
        end
        if (reg_wr && reg_addr == ADDR_W'(ADDR_CFG)) begin
            rg_d.win_len = reg_wdata[31:16];
            rg_d.unit    = unit_e'(reg_wdata[2:1]);
            rg_d.en      = reg_wdata[0];
            clr_now      = reg_wdata[0] && !rg_q.en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    // per-lane increments
    always_comb begin
        logic [SUM_W-1:0] tot;
        tot = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            lane_add[i] = xfer_vld[i] ? SUM_W'(xfer_bytes[i*BYTE_W +: BYTE_W]) : '0;
            tot         = tot + lane_add[i];
        end
        lane_add[NUM_MASTERS] = tot;
    end

    bwm_timebase #(
        .PRE_W (PRE_W),
        .WIN_W (WIN_W)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (rg_q.en),
        .presc   (rg_q.presc),
        .win_len (rg_q.win_len),
        .tick    (tick),
        .win_end (win_end)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        bwm_lane #(
            .CNT_W (CNT_W),
            .IN_W  (SUM_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr_now),
            .run     (rg_q.en),
            .win_end (win_end),
            .unit    (rg_q.unit),
            .add_val (lane_add[g]),
            .peak    (lane_peak[g]),
            .acc     (lane_acc[g])
        );
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_TIMER)) reg_rdata = DATA_W'(rg_q.presc);
        if (reg_addr == ADDR_W'(ADDR_CFG))   reg_rdata = {rg_q.win_len, 13'b0, rg_q.unit, rg_q.en};
        for (int i = 0; i < NUM_LANES; i++) begin
            if (reg_addr == ADDR_W'(int'(ADDR_PEAK_BASE) + 4*i)) reg_rdata = DATA_W'(lane_peak[i]);
        end
    end

endmodule

// File: rtl/bwm_chk.sv
module bwm_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             en,
    input logic             tick,
    input logic             win_end,
    input logic [CNT_W-1:0] pk_tot,
    input logic [CNT_W-1:0] pk_m0,
    input logic [CNT_W-1:0] acc_tot
);

    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en); // R9

    AST_WINEND_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> tick); // R3

    AST_CLEAR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pk_tot == '0 && pk_m0 == '0 && acc_tot == '0)); // R8

    AST_PEAK_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (pk_tot >= $past(pk_tot) && pk_m0 >= $past(pk_m0))); // R4

    AST_PEAK_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !win_end) |=> ($stable(pk_tot) && $stable(pk_m0))); // R3

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !win_end) |=> (acc_tot >= $past(acc_tot))); // R10

endmodule

bind peak_bw_monitor bwm_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_now),
    .en      (rg_q.en),
    .tick    (tick),
    .win_end (win_end),
    .pk_tot  (lane_peak[NUM_MASTERS]),
    .pk_m0   (lane_peak[0]),
    .acc_tot (lane_acc[NUM_MASTERS])
);

// File: tb/peak_bw_monitor_tb_top.sv
module peak_bw_monitor_tb_top;

    localparam int NM    = 5;
    localparam int BW    = 8;
    localparam int CW    = 24;
    localparam logic [7:0] A_TMR = 8'h00;
    localparam logic [7:0] A_CFG = 8'h04;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NM-1:0] xfer_vld = '0;
    logic [NM*BW-1:0] xfer_bytes = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    peak_bw_monitor #(
        .NUM_MASTERS (NM),
        .BYTE_W      (BW),
        .CNT_W       (CW),
        .PRE_W       (16),
        .ADDR_W      (8)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .xfer_vld   (xfer_vld),
        .xfer_bytes (xfer_bytes)
    );

    function automatic logic [31:0] cfgw(input logic [15:0] w, input logic [1:0] u, input logic e);
        return {w, 13'b0, u, e};
    endfunction

    function automatic logic [7:0] pk_addr(input int i);
        return 8'(160 + 4*i);
    endfunction

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=0x%02h actual=%0d expected=%0d", req, a, reg_rdata, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic drive(input int n, input logic [NM-1:0] v, input logic [NM*BW-1:0] b);
        xfer_vld = v; xfer_bytes = b;
        repeat (n) @(negedge clk);
        xfer_vld = '0; xfer_bytes = '0;
    endtask

    task automatic t_reset;
        chk_reg("R1", A_TMR, 0);
        chk_reg("R1", A_CFG, 0);
        for (int i = 0; i <= NM; i++) chk_reg("R1", pk_addr(i), 0);
    endtask

    task automatic t_regs;
        wr(A_TMR, 32'h0000_1234);
        chk_reg("R2", A_TMR, 32'h1234);
        wr(A_CFG, cfgw(16'h0003, 2'd1, 1'b0));
        chk_reg("R2", A_CFG, cfgw(16'h0003, 2'd1, 1'b0));
        chk_reg("R2", 8'h50, 0);
    endtask

    task automatic t_window;
        // T=1, W=1 -> 4-cycle window
        wr(A_TMR, 1);
        wr(A_CFG, cfgw(1, 0, 0));
        wr(A_CFG, cfgw(1, 0, 1));
        // m0 10, m1 7, m2 99 with valid low (R6)
        drive(3, 5'b00011, {8'd0, 8'd0, 8'd99, 8'd7, 8'd10});
        chk_reg("R3", pk_addr(0), 0);
        drive(1, 5'b00011, {8'd0, 8'd0, 8'd99, 8'd7, 8'd10});
        chk_reg("R3", pk_addr(0), 40);
        chk_reg("R5", pk_addr(1), 28);
        chk_reg("R6", pk_addr(2), 0);
        chk_reg("R5", pk_addr(NM), 68);
        // second window: m0 lighter, m1 heavier
        drive(4, 5'b00011, {8'd0, 8'd0, 8'd0, 8'd20, 8'd5});
        chk_reg("R4", pk_addr(0), 40);
        chk_reg("R4", pk_addr(1), 80);
        chk_reg("R5", pk_addr(NM), 100);
    endtask

    task automatic t_reenable;
        wr(A_CFG, cfgw(1, 0, 0));
        drive(8, 5'b00001, {8'd0, 8'd0, 8'd0, 8'd0, 8'd200});
        chk_reg("R9", pk_addr(0), 40);
        chk_reg("R9", pk_addr(NM), 100);
        wr(A_CFG, cfgw(1, 0, 1));
        chk_reg("R8", pk_addr(0), 0);
        chk_reg("R8", pk_addr(1), 0);
        chk_reg("R8", pk_addr(NM), 0);
        drive(4, 5'b01000, {8'd0, 8'd1, 8'd0, 8'd0, 8'd0});
        chk_reg("R8", pk_addr(3), 4);
    endtask

    task automatic t_kib;
        wr(A_TMR, 15);
        wr(A_CFG, cfgw(15, 1, 0));
        wr(A_CFG, cfgw(15, 1, 1));
        drive(256, 5'b11111, {NM{8'd255}});
        chk_reg("R7", pk_addr(0), 63);
        chk_reg("R7", pk_addr(NM), 318);
    endtask

    task automatic t_sat_mib;
        wr(A_TMR, 255);
        wr(A_CFG, cfgw(63, 0, 0));
        wr(A_CFG, cfgw(63, 0, 1));
        drive(16384, 5'b11111, {NM{8'd255}});
        chk_reg("R10", pk_addr(0), 4177920);
        chk_reg("R10", pk_addr(NM), 32'h00FF_FFFF);
        wr(A_CFG, cfgw(63, 2, 0));
        wr(A_CFG, cfgw(63, 2, 1));
        drive(16384, 5'b11111, {NM{8'd255}});
        chk_reg("R7", pk_addr(0), 3);
        chk_reg("R7", pk_addr(NM), 15);
        wr(A_CFG, cfgw(63, 3, 0));
        wr(A_CFG, cfgw(63, 3, 1));
        drive(16384, 5'b00001, {8'd0, 8'd0, 8'd0, 8'd0, 8'd255});
        chk_reg("R7", pk_addr(0), 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_window();
        t_reenable();
        t_kib();
        t_sat_mib();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule